// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block collects a set of external interrupt wires, up to 32 of them, and gives a host CPU one interrupt output per wire. Each wire first passes through a two-flop synchroniser. A per-line sense code then selects what counts as an event on that wire: a low level, a high level, a rising edge, a falling edge or either edge. Every line has a detect bit, which is gated by a per-line enable to form that line's request.

Software reaches the block over a simple 32-bit register bus. Writes complete in a single cycle, and a read returns data combinationally for the address currently presented. Through this bus software can:
- read the pending requests;
- enable lines with a write-one-to-set register and disable them with a write-one-to-clear register;
- acknowledge edge detections with a write-one-to-clear detect register;
- watch the synchronised input levels;
- program one 32-bit configuration word per line.

Software expects every bit of each configuration word to be stored, because it does read-modify-write on the whole word. Only the low six bits steer detection.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset all enables, detect bits, configuration words and interrupt outputs are zero.
- R2: A write to offset 0x08 sets the enable of every line whose data bit is 1 and leaves lines with a 0 bit unchanged; reading 0x04 or 0x08 returns the enable mask, bit n for line n.
- R3: A write to offset 0x04 clears the enable of every line whose data bit is 1 and leaves the others unchanged.
- R4: Reading offset 0x00 returns detect AND enable, and irq_out[n] equals bit n of that value; writes to 0x00 are ignored.
- R5: The configuration word of line n is at 0x180 + 4*n and reads back all 32 written bits. Its bits [5:0] select the sense: 0x01 low level, 0x02 high level, 0x04 falling edge, 0x08 rising edge, 0x0C both edges. Any other value, including 0, turns detection off and clears the line's detect bit on the next clock.
- R6: A change on irq_in reaches the detect bit and irq_out on the third rising clock edge after it is set up, and it reaches the level monitor on the second.
- R7: In a level mode the detect bit follows the active level of the synchronised input. Writing 1 to its detect-status bit has no effect while that level persists.
- R8: In an edge mode the detect bit sets on the selected edge and holds until a 1 is written to its bit at offset 0x100. An edge in the same cycle as that write leaves the bit set.
- R9: Offset 0x104 returns the synchronised input levels, bit n for line n, and writes to it are ignored.
- R10: Reads of an unmapped offset, or of a configuration word for a line index at or beyond the line count, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | External interrupt wires, asynchronous |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | N_LINES | Per-line interrupt toward the host |

## Verification
A corrupted detect bit shows up at the next sample of irq_out and of the request register, and it stays visible until the next acknowledge or mode change. A sticky bit that is lost in an edge mode therefore appears as a missing request, while a level-mode bit that fails to track its input shows up within three cycles of the input change. A wrong enable or configuration word can be observed directly through the bus on the cycle after the write that produced it. Each line is swept through every sense code, including an illegal one, so that a mis-decode is reported as a wrong bit position or a wrong level in the status reads.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int BUS_AW   = 12;
    localparam int BUS_DW   = 32;
    localparam int SENSE_W  = 6;
    localparam int MAX_LINE = 32;

    localparam logic [BUS_AW-1:0] OFS_REQ    = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_EN_CLR = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_EN_SET = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_DET    = 12'h100;
    localparam logic [BUS_AW-1:0] OFS_MON    = 12'h104;
    // configuration window 0x180..0x1FC: addr[11:7] == 3
    localparam logic [4:0]        CFG_PAGE   = 5'd3;

    typedef enum logic [2:0] {
        SNS_OFF,
        SNS_LOW,
        SNS_HIGH,
        SNS_FALL,
        SNS_RISE,
        SNS_BOTH
    } sense_e;

    // decoded bus access, one strobe per register class
    typedef struct packed {
        logic       en_set;
        logic       en_clr;
        logic       det_clr;
        logic       cfg_wr;
        logic       cfg_hit;
        logic [4:0] cfg_idx;
    } bus_dec_t;

    function automatic sense_e sense_decode(input logic [SENSE_W-1:0] code);
        case (code)
            6'h01:   return SNS_LOW;
            6'h02:   return SNS_HIGH;
            6'h04:   return SNS_FALL;
            6'h08:   return SNS_RISE;
            6'h0C:   return SNS_BOTH;
            default: return SNS_OFF;
        endcase
    endfunction

    function automatic logic sense_is_edge(input sense_e s);
        return (s == SNS_FALL) || (s == SNS_RISE) || (s == SNS_BOTH);
    endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/irq_line_det.sv
module irq_line_det
    import ext_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               lvl,
    input  logic [SENSE_W-1:0] code,
    input  logic               clr,
    output logic               det
);
    sense_e mode;
    logic   prev_q;
    logic   det_q;
    logic   det_d;
    logic   rise;
    logic   fall;
    logic   held;

    always_comb begin
        mode = sense_decode(code);
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        held = det_q & ~clr;
        case (mode)
            SNS_LOW:  det_d = ~lvl;
            SNS_HIGH: det_d = lvl;
            SNS_FALL: det_d = fall | held;
            SNS_RISE: det_d = rise | held;
            SNS_BOTH: det_d = rise | fall | held;
            default:  det_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            det_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            det_q  <= det_d;
        end
    end

    assign det = det_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import ext_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [BUS_AW-1:0]           addr,
    input  logic [BUS_DW-1:0]           wdata,
    input  logic [N-1:0]                det,
    input  logic [N-1:0]                lvl,
    output logic [N-1:0]                en,
    output logic [N-1:0]                det_clr,
    output logic [N-1:0][SENSE_W-1:0]   sense,
    output logic [BUS_DW-1:0]           rdata
);
    logic [N-1:0]              en_q;
    logic [N-1:0][BUS_DW-1:0]  cfg_q;
    logic [BUS_DW-1:0]         cfg_rd;
    bus_dec_t                  dec;

    always_comb begin
        dec.en_set  = we && (addr == OFS_EN_SET);
        dec.en_clr  = we && (addr == OFS_EN_CLR);
        dec.det_clr = we && (addr == OFS_DET);
        dec.cfg_hit = (addr[11:7] == CFG_PAGE) && (addr[1:0] == 2'b00);
        dec.cfg_wr  = we && dec.cfg_hit;
        dec.cfg_idx = addr[6:2];
    end

    assign det_clr = dec.det_clr ? wdata[N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (dec.en_set) begin
            en_q <= en_q | wdata[N-1:0];
        end else if (dec.en_clr) begin
            en_q <= en_q & ~wdata[N-1:0];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (dec.cfg_wr && (dec.cfg_idx == 5'(i))) begin
                cfg_q[i] <= wdata;
            end
        end
        assign sense[i] = cfg_q[i][SENSE_W-1:0];
    end

    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < N; i++) begin
            if (dec.cfg_idx == 5'(i)) cfg_rd = cfg_q[i];
        end
    end

    always_comb begin
        if (dec.cfg_hit)               rdata = cfg_rd;
        else if (addr == OFS_REQ)      rdata = BUS_DW'(det & en_q);
        else if (addr == OFS_EN_CLR)   rdata = BUS_DW'(en_q);
        else if (addr == OFS_EN_SET)   rdata = BUS_DW'(en_q);
        else if (addr == OFS_DET)      rdata = BUS_DW'(det);
        else if (addr == OFS_MON)      rdata = BUS_DW'(lvl);
        else                           rdata = '0;
    end

    assign en = en_q;
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
    import ext_irq_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_LINES-1:0]   irq_in,
    input  logic                 bus_we,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    output logic [N_LINES-1:0]   irq_out
);
    logic [N_LINES-1:0]               lvl;
    logic [N_LINES-1:0]               en_q;
    logic [N_LINES-1:0]               det;
    logic [N_LINES-1:0]               det_clr;
    logic [N_LINES-1:0][SENSE_W-1:0]  sense;
    logic [N_LINES-1:0]               edge_mode;
    logic [N_LINES-1:0]               off_mode;

    irq_sync2 #(.W(N_LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (lvl)
    );

    irq_regs #(.N(N_LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .det     (det),
        .lvl     (lvl),
        .en      (en_q),
        .det_clr (det_clr),
        .sense   (sense),
        .rdata   (bus_rdata)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_line_det u_det (
            .clk  (clk),
            .rst  (rst),
            .lvl  (lvl[g]),
            .code (sense[g]),
            .clr  (det_clr[g]),
            .det  (det[g])
        );
        assign edge_mode[g] = sense_is_edge(sense_decode(sense[g]));
        assign off_mode[g]  = (sense_decode(sense[g]) == SNS_OFF);
    end

    assign irq_out = det & en_q;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
    import ext_irq_pkg::*;
#(
    parameter int N = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_we,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic [BUS_DW-1:0]  bus_wdata,
    input logic [N-1:0]       irq_out,
    input logic [N-1:0]       en,
    input logic [N-1:0]       det,
    input logic [N-1:0]       det_clr,
    input logic [N-1:0]       edge_mode,
    input logic [N-1:0]       off_mode
);
    // R2
    en_set_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN_SET) |=>
            ((en & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    // R2
    en_set_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN_SET) |=>
            (((en ^ $past(en)) & ~$past(bus_wdata[N-1:0])) == '0));

    // R3
    en_clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN_CLR) |=>
            ((en & $past(bus_wdata[N-1:0])) == '0));

    // R4
    req_gated_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_out & ~en) == '0));

    // R8
    edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(det & edge_mode & ~det_clr) & edge_mode) & ~det) == '0));

    // R5
    off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(off_mode) & det) == '0));
endmodule

bind ext_irq_sense_ctrl ext_irq_chk #(.N(N_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .en        (en_q),
    .det       (det),
    .det_clr   (det_clr),
    .edge_mode (edge_mode),
    .off_mode  (off_mode)
);

// File: tb/test_ext_irq_sense_ctrl.sv
module test_ext_irq_sense_ctrl;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ext_irq_sense_ctrl #(.N_LINES(N)) i_ext_irq_sense_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive_in(input logic [N-1:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [5:0] code_of(input int k);
        case (k)
            0: return 6'h00;
            1: return 6'h01;
            2: return 6'h02;
            3: return 6'h04;
            4: return 6'h08;
            5: return 6'h0C;
            default: return 6'h03;
        endcase
    endfunction

    task automatic check_line(input string req, input int l, input logic e);
        logic [31:0] v;
        logic [31:0] x;
        x = 32'(e) << l;
        rd(12'h100, v);
        chk({req, " detect"}, v, x);
        rd(12'h000, v);
        chk({req, " request"}, v, x);
        chk({req, " irq_out"}, 32'(irq_out), x);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0]  c;
        logic [31:0] cv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(12'h000, v); chk("R1 request", v, 0);
        rd(12'h004, v); chk("R1 enable", v, 0);
        rd(12'h100, v); chk("R1 detect", v, 0);
        for (int i = 0; i < N; i++) begin
            rd(12'h180 + 12'(4 * i), v); chk("R1 config", v, 0);
        end
        chk("R1 irq_out", 32'(irq_out), 0);

        // R2 / R3: partial set and clear masks
        wr(12'h008, 32'h5);
        rd(12'h008, v); chk("R2 set 0101", v, 32'h5);
        wr(12'h008, 32'h2);
        rd(12'h004, v); chk("R2 set keeps others", v, 32'h7);
        wr(12'h004, 32'h4);
        rd(12'h004, v); chk("R3 clear bit2", v, 32'h3);
        wr(12'h004, 32'h0);
        rd(12'h008, v); chk("R3 zero clear no effect", v, 32'h3);
        wr(12'h004, 32'hF);
        rd(12'h004, v); chk("R3 clear all", v, 0);

        // R9 / R10: monitor and unmapped
        drive_in(4'hA);
        rd(12'h104, v); chk("R9 monitor", v, 32'hA);
        wr(12'h104, 32'h5);
        rd(12'h104, v); chk("R9 monitor write ignored", v, 32'hA);
        drive_in(4'h0);
        rd(12'h1F0, v); chk("R10 unmapped", v, 0);
        rd(12'h180 + 12'(4 * N), v); chk("R10 config beyond lines", v, 0);
        rd(12'h00C, v); chk("R10 unmapped low", v, 0);

        // R6: latency, line 2 high level, enabled
        wr(12'h188, 32'h2);
        wr(12'h008, 32'h4);
        @(negedge clk); irq_in = 4'h4;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 irq_out not yet", 32'(irq_out), 0);
        bus_addr = 12'h104; #1;
        chk("R6 monitor after two edges", bus_rdata, 32'h4);
        @(posedge clk);
        @(negedge clk);
        chk("R6 irq_out after three edges", 32'(irq_out), 32'h4);
        drive_in(4'h0);
        wr(12'h188, 32'h0);
        wr(12'h004, 32'hF);

        // R4: enable gating and ignored write to request register
        wr(12'h184, 32'h2);
        drive_in(4'h2);
        rd(12'h100, v); chk("R4 detect without enable", v, 32'h2);
        rd(12'h000, v); chk("R4 request gated", v, 0);
        chk("R4 irq_out gated", 32'(irq_out), 0);
        wr(12'h000, 32'hF);
        rd(12'h000, v); chk("R4 request write ignored", v, 0);
        rd(12'h004, v); chk("R4 enable untouched", v, 0);
        wr(12'h008, 32'h2);
        rd(12'h000, v); chk("R4 request enabled", v, 32'h2);
        drive_in(4'h0);
        wr(12'h184, 32'h0);
        wr(12'h004, 32'hF);

        // R8: edge vs clear race, line 0 both edges
        wr(12'h180, 32'hC);
        wr(12'h008, 32'h1);
        drive_in(4'h1);
        rd(12'h100, v); chk("R8 rise sets", v, 32'h1);
        @(negedge clk); irq_in = 4'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h100; bus_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        rd(12'h100, v); chk("R8 edge beats clear", v, 32'h1);
        wr(12'h100, 32'h1);
        rd(12'h100, v); chk("R8 clear without edge", v, 0);
        wr(12'h180, 32'h0);
        wr(12'h004, 32'hF);

        // sweep of every line through every sense code
        for (int l = 0; l < N; l++) begin
            for (int k = 0; k < 7; k++) begin
                c  = code_of(k);
                cv = 32'hC35A_9E40 | 32'(c);
                drive_in(4'h0);
                wr(12'h100, 32'hF);
                wr(12'h004, 32'hF);
                wr(12'h008, 32'(1) << l);
                wr(12'h180 + 12'(4 * l), cv);
                @(posedge clk);
                // R7 low level active while input is 0
                check_line("R7 idle low", l, c == 6'h01);
                drive_in(4'(1 << l));
                // R8 rising edge / R7 high level
                check_line("R8 after rise", l, c == 6'h02 || c == 6'h08 || c == 6'h0C);
                wr(12'h100, 32'hF);
                // R7 clear ignored while level held, R8 edge bits cleared
                check_line("R7 clear while held", l, c == 6'h02);
                drive_in(4'h0);
                check_line("R8 after fall", l, c == 6'h01 || c == 6'h04 || c == 6'h0C);
                rd(12'h180 + 12'(4 * l), v);
                chk("R5 config readback", v, cv);
                wr(12'h180 + 12'(4 * l), 32'h0);
                rd(12'h100, v);
                chk("R5 off clears detect", v, 0);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule